// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block is a synchronous master that runs one complete conversion cycle on an external 12-bit serial analog-to-digital converter. The converter is set to external-clock mode, and the controller generates the shared serial clock. A start pulse begins the cycle. The controller drives chip select low and sends a command byte built from a 5-bit configuration field. It then stops the serial clock and waits for the converter's strobe line to fall. After that it clocks in a 16-bit reply, keeps the first 12 bits as the result, releases chip select and reports the result with a one-cycle valid pulse.

The strobe line comes from outside the clock domain, so it passes through a two-flop synchroniser before its falling edge is detected. If the strobe does not fall within a set number of system clock cycles, a watchdog ends the cycle. It releases chip select and raises an error flag. The serial clock rate comes from a divider parameter, `HALF_CYC` system cycles for each half period.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and busy, valid and error are all low.
- R2: A start pulse seen while idle drives chip select low and raises busy on the next cycle. A start pulse that arrives while busy has no effect on the command byte or on the number of cycles run.
- R3: The command is 8 bits, sent most significant bit first on the data-in line: bit 7 = 1, bits 6..2 = the configuration field (cfg_i[4] in bit 6), bits 1..0 = 11. Each bit changes only at a falling serial clock edge, so it is stable at every rising edge.
- R4: The serial clock is active-high with a period of 2*HALF_CYC system cycles. It is low whenever chip select is high.
- R5: Between the last command bit and the detected falling edge of the strobe, the serial clock stays low and no result bit is clocked.
- R6: After the strobe edge there are exactly 16 rising serial clock edges. The result is the first 12 bits sampled, with the first one as the most significant bit. The last 4 sampled bits do not affect the result.
- R7: Chip select goes high after the 16th bit. valid_o is then high for exactly one cycle, with chip select already high. Busy drops on the cycle after valid, and chip select stays high until the next accepted start.
- R8: If no strobe falling edge is detected within TIMEOUT_CYC system cycles of entering the wait, the cycle is abandoned. Chip select goes high, busy drops, error_o is set and no valid pulse is produced. The next accepted start clears error_o.
- R9: A strobe edge detected in the same cycle as the last timeout cycle takes priority, and the conversion completes normally with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle conversion request |
| cfg_i | input | 5 | Configuration field placed in the command byte |
| adc_dout_i | input | 1 | Serial data from the converter |
| adc_strb_i | input | 1 | Converter strobe; its falling edge marks data ready |
| adc_cs_n_o | output | 1 | Active-low chip select |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_din_o | output | 1 | Serial command data to the converter |
| result_o | output | 12 | Conversion result, valid with valid_o |
| valid_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | High from an accepted start until the cycle ends |
| error_o | output | 1 | Set when the strobe wait times out |

## Verification
The one real collision in this block is the strobe falling edge reaching the sequencer in the same cycle that the wait counter expires. The bench sets this up by counting system cycles from the last command clock edge. It drops the strobe exactly three cycles before the timeout expires, which covers the two synchroniser flops and the edge register. It then repeats the run with the strobe one cycle later. The first run must finish with a correct result and no error. The second must abort with error set and no valid pulse. A second overlap, a start request arriving during a running cycle, is judged by checking that the command byte, the bit count and the single valid pulse are unchanged.

// File: rtl/adc_ctrl_pkg.sv
// Package: shared types for the serial ADC conversion controller.
// Assumes: nothing beyond standard SystemVerilog.
package adc_ctrl_pkg;

    // Sequencer states for one conversion cycle.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEND = 3'd1,
        ST_WAIT = 3'd2,
        ST_READ = 3'd3,
        ST_DONE = 3'd4
    } ctl_state_t;

    // Build the command word: start marker, configuration field, mode bits 11.
    function automatic logic [7:0] make_cmd(input logic [4:0] cfg);
        return {1'b1, cfg, 2'b11};
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
// Module: adc_sclk_gen
// Makes the serial clock from the system clock by counting HALF_CYC cycles
// per half period. It also gives single-cycle pulses in the cycle whose
// closing edge raises or lowers the serial clock.
// Assumes: run_i is only dropped on a cycle where the clock is low or falls.
module adc_sclk_gen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          tick;

    assign tick   = run_i && (cnt_q == LAST);
    assign rise_o = tick && !sclk_q;
    assign fall_o = tick && sclk_q;
    assign sclk_o = sclk_q;

    // Half-period counter and clock toggle; both held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R4: a stopped divider leaves the serial clock low.
    assert_gated_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sclk_q);

endmodule

// File: rtl/adc_strb_sync.sv
// Module: adc_strb_sync
// Brings the asynchronous strobe into the clock domain through STAGES flops,
// then flags a high-to-low change of the synchronised value.
// Assumes: the strobe idles low, so the chain resets to zero.
module adc_strb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_i,
    output logic fall_o
);
    logic [STAGES:0] chain_q;

    // Synchroniser chain plus one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], strb_i};
    end

    assign fall_o = chain_q[STAGES] && !chain_q[STAGES-1];

    // R5: an edge pulse never lasts two cycles.
    assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/adc_bit_shifter.sv
// Module: adc_bit_shifter
// Holds the outgoing command shift register, the incoming reply shift
// register and a shared count of sampled rising edges.
// Assumes: sample_i pulses once per rising serial edge; MSB first both ways.
module adc_bit_shifter #(
    parameter int TX_W  = 8,
    parameter int RX_W  = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TX_W-1:0]  tx_word_i,
    input  logic             clr_i,
    input  logic             tx_adv_i,
    input  logic             sample_i,
    input  logic             rx_bit_i,
    output logic             tx_bit_o,
    output logic [RX_W-1:0]  rx_word_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int MAXW = (TX_W > RX_W) ? TX_W : RX_W;

    logic [TX_W-1:0]  tx_q;
    logic [RX_W-1:0]  rx_q;
    logic [CNT_W-1:0] cnt_q;

    // Command register: load at start, shift left at each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (load_i)   tx_q <= tx_word_i;
        else if (tx_adv_i) tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end

    // Reply register: take one bit in at each sampled rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (sample_i) rx_q <= {rx_q[RX_W-2:0], rx_bit_i};
    end

    // Edge counter: cleared at the start of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i || clr_i) cnt_q <= '0;
        else if (sample_i)             cnt_q <= cnt_q + 1'b1;
    end

    assign tx_bit_o  = tx_q[TX_W-1];
    assign rx_word_o = rx_q;
    assign cnt_o     = cnt_q;

    // R6: the counter never passes the longest phase.
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAXW));

endmodule

// File: rtl/adc_conv_ctrl.sv
// Module: adc_conv_ctrl (top)
// Runs one conversion on an external serial ADC: command out, wait for the
// strobe to fall, 16-bit read, 12-bit result with valid. A watchdog ends the
// strobe wait after TIMEOUT_CYC cycles.
// Assumes: start_i is synchronous; adc_strb_i and adc_dout_i are external.
module adc_conv_ctrl #(
    parameter int HALF_CYC    = 2,
    parameter int TIMEOUT_CYC = 65536,
    parameter int CFG_W       = 5,
    parameter int RX_W        = 16,
    parameter int RES_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             adc_dout_i,
    input  logic             adc_strb_i,
    output logic             adc_cs_n_o,
    output logic             adc_sclk_o,
    output logic             adc_din_o,
    output logic [RES_W-1:0] result_o,
    output logic             valid_o,
    output logic             busy_o,
    output logic             error_o
);
    import adc_ctrl_pkg::*;

    localparam int TX_W  = CFG_W + 3;
    localparam int MAXW  = (TX_W > RX_W) ? TX_W : RX_W;
    localparam int CNT_W = $clog2(MAXW + 1);
    localparam int TO_W  = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [TO_W-1:0]  TO_LAST = TO_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] TX_END  = CNT_W'(TX_W);
    localparam logic [CNT_W-1:0] RX_END  = CNT_W'(RX_W);

    ctl_state_t       st_q, st_d;
    logic [TO_W-1:0]  wcnt_q;
    logic             err_q;
    logic [RES_W-1:0] res_q;

    logic             run, rise, fall, sclk;
    logic             strb_fall;
    logic             load, clr, tx_adv;
    logic             tx_bit;
    logic [RX_W-1:0]  rx_word;
    logic [CNT_W-1:0] cnt;
    logic [TX_W-1:0]  cmd_word;

    assign cmd_word = {1'b1, cfg_i, 2'b11};
    assign run      = (st_q == ST_SEND) || (st_q == ST_READ);
    assign tx_adv   = (st_q == ST_SEND) && fall;

    adc_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .sclk_o(sclk), .rise_o(rise), .fall_o(fall)
    );

    adc_strb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .strb_i(adc_strb_i), .fall_o(strb_fall)
    );

    adc_bit_shifter #(.TX_W(TX_W), .RX_W(RX_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(load), .tx_word_i(cmd_word),
        .clr_i(clr), .tx_adv_i(tx_adv), .sample_i(rise),
        .rx_bit_i(adc_dout_i), .tx_bit_o(tx_bit), .rx_word_o(rx_word),
        .cnt_o(cnt)
    );

    // Next-state logic; a strobe edge wins over the timeout in the same cycle.
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        clr  = 1'b0;
        case (st_q)
            ST_IDLE: if (start_i) begin
                st_d = ST_SEND;
                load = 1'b1;
            end
            ST_SEND: if (fall && cnt == TX_END) st_d = ST_WAIT;
            ST_WAIT: if (strb_fall) begin
                st_d = ST_READ;
                clr  = 1'b1;
            end else if (wcnt_q == TO_LAST) begin
                st_d = ST_IDLE;
            end
            ST_READ: if (fall && cnt == RX_END) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Strobe-wait counter, running only while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || st_q != ST_WAIT) wcnt_q <= '0;
        else                           wcnt_q <= wcnt_q + 1'b1;
    end

    // Error flag: set on timeout abort, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (st_q == ST_IDLE && start_i)
            err_q <= 1'b0;
        else if (st_q == ST_WAIT && !strb_fall && wcnt_q == TO_LAST)
            err_q <= 1'b1;
    end

    // Result register: keep the leading RES_W bits at the end of the read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else if (st_q == ST_READ && st_d == ST_DONE)
            res_q <= rx_word[RX_W-1 -: RES_W];
    end

    assign adc_cs_n_o = !((st_q == ST_SEND) || (st_q == ST_WAIT) || (st_q == ST_READ));
    assign adc_sclk_o = sclk;
    assign adc_din_o  = (st_q == ST_SEND) ? tx_bit : 1'b0;
    assign result_o   = res_q;
    assign valid_o    = (st_q == ST_DONE);
    assign busy_o     = (st_q != ST_IDLE);
    assign error_o    = err_q;

    // R4: no serial clock while deselected.
    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n_o |-> !adc_sclk_o);
    // R5: clock held low during the strobe wait.
    assert_wait_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> !adc_sclk_o);
    // R2: a selected converter always means busy.
    assert_busy_cover_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n_o |-> busy_o);
    // R7: valid is a single-cycle pulse with chip select released.
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_valid_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> adc_cs_n_o);
    // R8: an abort leaves the converter deselected and the block idle.
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> (adc_cs_n_o && !busy_o && !valid_o));
    // R6: the read phase never counts past the reply length.
    assert_read_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READ) |-> (cnt <= RX_END));

endmodule

// File: tb/adc_conv_ctrl_tb.sv
// Bench: a behavioural converter model drives the strobe and data lines. A
// per-clock monitor compares port relations every cycle, and tasks check
// each conversion against values computed from the requirements.
module adc_conv_ctrl_tb;
    localparam int HALF = 2;
    localparam int TO   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  cfg = '0;
    logic        dout = 1'b0;
    logic        strb = 1'b0;
    logic        cs_n, sclk, din, valid, busy, err;
    logic [11:0] res;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_conv_ctrl #(.HALF_CYC(HALF), .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_i(cfg),
        .adc_dout_i(dout), .adc_strb_i(strb), .adc_cs_n_o(cs_n),
        .adc_sclk_o(sclk), .adc_din_o(din), .result_o(res),
        .valid_o(valid), .busy_o(busy), .error_o(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            chk(1'b0, "WD", "watchdog expired", cyc, 100000);
            finish_run();
        end
    end

    // Per-clock monitor of port relations.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cs_n) chk(!sclk, "R4", "sclk high while deselected", sclk, 0);
            if (!cs_n) chk(busy, "R2", "selected but not busy", busy, 1);
            if (valid) chk(cs_n, "R7", "valid with cs low", cs_n, 1);
        end
    end

    // One full conversion. fall_dly: cycles from the last command clock fall
    // to the strobe drop. expect_to: the wait should time out instead.
    task automatic do_conv(input logic [4:0] c, input logic [15:0] word,
                           input int fall_dly, input bit expect_to,
                           input bit poke);
        logic [7:0] cmd = '0;
        int rises = 0;
        int last_rise = -1;
        int n = 0;
        bit prev;
        bit clk_in_wait = 1'b0;
        int valids = 0;
        logic [11:0] got = '0;

        @(negedge clk); start = 1'b1; cfg = c;
        @(negedge clk); start = 1'b0;
        chk(!cs_n && busy, "R2", "select after start", {cs_n, busy}, 2'b01);
        chk(err == 1'b0, "R8", "error cleared by start", err, 0);

        // Collect the command byte.
        prev = sclk;
        while (1) begin
            @(negedge clk); n++;
            if (poke && rises == 3 && !start) begin start = 1'b1; cfg = ~c; end
            else start = 1'b0;
            if (sclk && !prev) begin
                cmd = {cmd[6:0], din};
                if (last_rise >= 0)
                    chk(n - last_rise == 2*HALF, "R4", "sclk period", n - last_rise, 2*HALF);
                last_rise = n;
                rises++;
            end
            if (!sclk && prev && rises == 8) break;
            prev = sclk;
            if (n > 500) break;
        end
        start = 1'b0;
        chk(cmd == {1'b1, c, 2'b11}, "R3", "command byte", cmd, {1'b1, c, 2'b11});

        // Strobe wait: raise, then drop at the chosen cycle.
        for (int i = 1; i < fall_dly; i++) begin
            @(negedge clk);
            if (i == 1) strb = 1'b1;
            if (sclk) clk_in_wait = 1'b1;
        end
        @(negedge clk);
        if (sclk) clk_in_wait = 1'b1;
        strb = 1'b0;
        dout = word[15];
        chk(!clk_in_wait, "R5", "sclk during strobe wait", clk_in_wait, 0);

        if (expect_to) begin
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (valid) valids++;
            end
            chk(err && !busy && cs_n, "R8", "timeout abort", {err, busy, cs_n}, 3'b101);
            chk(valids == 0, "R8", "no valid after abort", valids, 0);
            return;
        end

        // Read phase: the model shifts data on each falling edge.
        rises = 0; prev = sclk; n = 0;
        while (!valid && n < 2000) begin
            @(negedge clk); n++;
            if (sclk && !prev) rises++;
            if (!sclk && prev && rises < 16) dout = word[15 - rises];
            prev = sclk;
        end
        got = res;
        chk(valid, "R7", "valid seen", valid, 1);
        chk(rises == 16, "R6", "read edge count", rises, 16);
        chk(got == word[15:4], "R6", "result value", got, word[15:4]);
        chk(!err, "R9", "no error on completed cycle", err, 0);
        @(negedge clk);
        chk(!valid && !busy, "R7", "valid pulse and busy drop", {valid, busy}, 0);
        for (int i = 0; i < 12; i++) @(negedge clk);
        chk(cs_n && !busy, "R7", "stays deselected", {cs_n, busy}, 2'b10);
        dout = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !valid && !busy && !err, "R1", "reset state",
            {cs_n, sclk, valid, busy, err}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !busy, "R1", "idle after reset", {cs_n, busy}, 2'b10);

        do_conv(5'b10110, 16'hA5C3, 10, 1'b0, 1'b0);  // R3 R6: trailing 3 ignored
        do_conv(5'b01001, 16'h3C0F, 6, 1'b0, 1'b0);   // R6: trailing F ignored
        do_conv(5'b11111, 16'hFFF0, 20, 1'b0, 1'b1);  // R2: start while busy
        do_conv(5'b00000, 16'h0005, 12, 1'b0, 1'b0);
        do_conv(5'b00111, 16'h1234, TO - 3, 1'b0, 1'b0); // R9: edge meets expiry
        do_conv(5'b11000, 16'h8888, TO - 2, 1'b1, 1'b0); // R8: one cycle late
        do_conv(5'b10101, 16'h7E2A, 8, 1'b0, 1'b0);   // R8: error cleared
        finish_run();
    end
endmodule